// File: doc/BRIEF.md
# Byte-wide SPI master with register access

This block is a serial peripheral interface master that exchanges one byte at a time with a single attached device. Software sets it up and drives it over a simple word-addressed register bus. A control register holds the serial clock divider and the clock polarity and phase. A system register enables master operation and sets the chip-select level directly. Writing a byte to the transmit register starts a full-duplex exchange of eight bits.

When the exchange ends, the byte captured from the device is held in the receive register and a flag in the status word is raised. Software learns of progress only by polling. There are no interrupts and no queue beyond the single receive byte.

The serial clock half-period is a fixed prescale of 16 or 128 system clocks, multiplied by a programmable factor of 1 to 32. The full serial period is therefore the prescale times an even divide of 2 to 64.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads 0, `cs_n` is 1 and `sclk` is 0.
- R2: The serial half-period is P*(N+1) system clocks. N is control bits [4:0]. P is 16 when control bit 5 is 0 and 128 when it is 1. The first `sclk` edge comes one half-period after the clock edge that accepts the transmit write. An exchange has exactly 16 `sclk` edges.
- R3: Control bit 6 (polarity) is the idle level of `sclk`, and `sclk` returns to it after each exchange. Control bit 7 (phase) selects the edge pairing. With phase 0, data is sampled on the first edge of each bit and changes on the second, and the first bit is driven from the start. With phase 1, data changes on the first edge and is sampled on the second. Bits go out most significant first.
- R4: The received byte is read from offset 0x10 in bits [7:0], with the upper bits 0. It stays readable until the next exchange ends.
- R5: Status (offset 0x04) bit 0 reads 1 from the cycle after an accepted transmit write until the last `sclk` edge, and 0 otherwise.
- R6: Status bit 2 is set when an exchange ends. A read of offset 0x10 clears it. A write to offset 0x04 with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged.
- R7: A write to the transmit register (offset 0x0C) while status bit 0 is 1 is ignored. It neither alters the byte in flight nor starts a further exchange.
- R8: System register (offset 0x08) bit 0 enables master operation and bit 6 sets the chip-select level. `cs_n` is 0 only when bit 0 is 1 and bit 6 is 0, so writing 0x21 asserts chip select.
- R9: A transmit write while system bit 0 is 0 starts nothing.
- R10: Control (0x00), system (0x08) and auxiliary control (0x14) read back the low 8 bits last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 1 | Chip select, active low |

## Verification
A corrupted edge or bit counter shows up at the pins within one byte. `sclk` then has a number of edges other than sixteen, rests at the wrong level, or the byte seen by the device is shifted by a bit. A wrong divide value changes the first edge time after the transmit write, and that error appears within one half-period. A stuck busy or receive flag is seen on the next status poll. The bench models the attached device at the pins. It sweeps all four clock modes over several divider settings and byte patterns.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int PRESC_LO = 16,
  parameter int PRESC_HI = 128,
  parameter int DIVN_W   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int HALF_MAX = PRESC_HI * (2 ** DIVN_W);
  localparam int CW       = $clog2(HALF_MAX + 1);
  localparam logic [2:0] W_CTRL = 3'd0, W_STAT = 3'd1, W_SYS = 3'd2,
                         W_TX = 3'd3, W_RX = 3'd4, W_CTRL2 = 3'd5;

  logic [7:0]    ctrl_q, sysctl_q, ctrl2_q, rx_buf_q, tx_sr_q, rx_sr_q;
  logic          busy_q, rxfull_q, sclk_q, mosi_q;
  logic [CW-1:0] cnt_q, half_len;
  logic [3:0]    edge_q;

  wire [2:0] widx   = bus_addr[4:2];
  wire       cpha   = ctrl_q[7];
  wire       cpol   = ctrl_q[6];
  wire       msten  = sysctl_q[0];
  wire       start  = bus_wr && (widx == W_TX) && !busy_q && msten;
  wire       tick   = busy_q && (cnt_q == half_len - CW'(1));
  wire       smp    = (edge_q[0] == cpha);
  wire [7:0] rx_nxt = smp ? {rx_sr_q[6:0], miso} : rx_sr_q;
  wire       unused_bits = &{1'b0, bus_addr[1:0], bus_wdata[31:8]};

  assign half_len = (ctrl_q[5] ? CW'(PRESC_HI) : CW'(PRESC_LO)) *
                    (CW'(ctrl_q[DIVN_W-1:0]) + CW'(1));

  assign sclk = busy_q ? sclk_q : cpol;
  assign mosi = mosi_q;
  assign cs_n = ~(msten & ~sysctl_q[6]);

  always_comb begin
    bus_rdata = '0;
    case (widx)
      W_CTRL:  bus_rdata[7:0] = ctrl_q;
      W_STAT:  bus_rdata[2:0] = {rxfull_q, 1'b0, busy_q};
      W_SYS:   bus_rdata[7:0] = sysctl_q;
      W_RX:    bus_rdata[7:0] = rx_buf_q;
      W_CTRL2: bus_rdata[7:0] = ctrl2_q;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sysctl_q <= '0;
      ctrl2_q  <= '0;
    end else if (bus_wr) begin
      case (widx)
        W_CTRL:  ctrl_q   <= bus_wdata[7:0];
        W_SYS:   sysctl_q <= bus_wdata[7:0];
        W_CTRL2: ctrl2_q  <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rxfull_q <= 1'b0;
    else if (tick && edge_q == 4'd15)
      rxfull_q <= 1'b1;
    else if (bus_wr && widx == W_STAT)
      rxfull_q <= rxfull_q & bus_wdata[2];
    else if (bus_rd && widx == W_RX)
      rxfull_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      cnt_q    <= '0;
      edge_q   <= '0;
      tx_sr_q  <= '0;
      rx_sr_q  <= '0;
      rx_buf_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      edge_q  <= '0;
      sclk_q  <= cpol;
      rx_sr_q <= '0;
      if (cpha) begin
        tx_sr_q <= bus_wdata[7:0];
      end else begin
        mosi_q  <= bus_wdata[7];
        tx_sr_q <= {bus_wdata[6:0], 1'b0};
      end
    end else if (busy_q) begin
      if (tick) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 4'd1;
        if (smp) begin
          rx_sr_q <= rx_nxt;
        end else begin
          mosi_q  <= tx_sr_q[7];
          tx_sr_q <= {tx_sr_q[6:0], 1'b0};
        end
        if (edge_q == 4'd15) begin
          busy_q   <= 1'b0;
          rx_buf_q <= rx_nxt;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

module spi_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] widx,
  input logic       wd0,
  input logic       wd6,
  input logic       sclk,
  input logic       cs_n,
  input logic       busy,
  input logic       rxfull,
  input logic       cpol,
  input logic       msten
);
  AST_CS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == 3'd2) |=> (cs_n == ~($past(wd0) & ~$past(wd6)))); // R8

  AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sclk == cpol)); // R3

  AST_RXFULL_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxfull) |-> $fell(busy)); // R6

  AST_RXREAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && widx == 3'd4 && !busy) |=> !rxfull); // R6

  AST_START_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(msten)); // R9
endmodule

bind spi_byte_master spi_byte_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .widx(bus_addr[4:2]), .wd0(bus_wdata[0]), .wd6(bus_wdata[6]),
  .sclk(sclk), .cs_n(cs_n), .busy(busy_q), .rxfull(rxfull_q),
  .cpol(ctrl_q[6]), .msten(sysctl_q[0])
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sclk, mosi, miso, cs_n;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0, b_cpol = 0, b_cpha = 0;
  int n_edge = 0, sidx = 0;
  time t_wr = 0, t_first = 0, t_last = 0;
  logic [7:0] s_tx = '0, s_rx = '0;

  always #5 clk = ~clk;

  spi_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  assign miso = (sidx < 8) ? s_tx[3'(7 - sidx)] : 1'b0;

  always @(sclk) begin
    if (mon_on) begin
      n_edge <= n_edge + 1;
      if (n_edge == 0) t_first <= $time;
      t_last <= $time;
      if (b_cpha ? (sclk == b_cpol) : (sclk != b_cpol)) begin
        s_rx <= {s_rx[6:0], mosi};
        sidx <= sidx + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    t_wr = $time + 5;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic xfer(input bit cpol, input bit cpha, input bit phi, input logic [4:0] n,
                      input logic [7:0] txb, input logic [7:0] stxb);
    logic [31:0] rv;
    int half;
    half = (phi ? 128 : 16) * (int'(n) + 1);
    b_cpol = cpol; b_cpha = cpha;
    bwr(5'h00, {24'h0, cpha, cpol, phi, n});
    s_tx = stxb; sidx = 0; s_rx = '0; n_edge = 0; mon_on = 1;
    bwr(5'h0C, {24'h0, txb});
    repeat (16 * half + 3) @(posedge clk);
    mon_on = 0;
    #1;
    chk(s_rx == txb, "R3 byte seen by device", s_rx, txb);
    chk(n_edge == 16, "R2 edge count", n_edge, 16);
    chk((t_first - t_wr) == time'(half * 10), "R2 first edge delay", 32'(t_first - t_wr), half * 10);
    chk((t_last - t_first) == time'(15 * half * 10), "R2 period", 32'(t_last - t_first), 15 * half * 10);
    chk(sclk == cpol, "R3 idle level", sclk, cpol);
    brd(5'h04, rv);
    chk(rv == 32'h4, "R5 R6 status after exchange", rv, 32'h4);
    brd(5'h10, rv);
    chk(rv == {24'h0, stxb}, "R4 received byte", rv, {24'h0, stxb});
    brd(5'h04, rv);
    chk(rv == 32'h0, "R6 read clears full", rv, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    for (int a = 0; a < 6; a++) begin
      brd(5'(a * 4), rv);
      chk(rv == 32'h0, "R1 register reset", rv, 0);
    end

    bwr(5'h14, 32'hFFFF_FFA5); brd(5'h14, rv);
    chk(rv == 32'hA5, "R10 aux control", rv, 32'hA5);
    bwr(5'h00, 32'h0000_12C3); brd(5'h00, rv);
    chk(rv == 32'hC3, "R10 control", rv, 32'hC3);
    bwr(5'h00, 32'h0);
    bwr(5'h08, 32'h21); brd(5'h08, rv);
    chk(rv == 32'h21, "R10 system", rv, 32'h21);
    chk(cs_n == 1'b0, "R8 cs asserted", cs_n, 0);
    bwr(5'h08, 32'h61); #1;
    chk(cs_n == 1'b1, "R8 cs level bit", cs_n, 1);
    bwr(5'h08, 32'h20); #1;
    chk(cs_n == 1'b1, "R8 cs needs master", cs_n, 1);

    n_edge = 0; mon_on = 1;
    bwr(5'h0C, 32'h55);
    repeat (600) @(posedge clk);
    mon_on = 0; #1;
    chk(n_edge == 0, "R9 no edges without master", n_edge, 0);
    brd(5'h04, rv);
    chk(rv == 32'h0, "R9 status idle", rv, 0);

    bwr(5'h08, 32'h21);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 3; k++)
        for (int p = 0; p < 2; p++) begin
          logic [7:0] tb_b, sl_b;
          tb_b = 8'(8'h96 + m * 53 + k * 17 + p * 91);
          sl_b = ~tb_b ^ 8'(8'h3C + p * 8'h81);
          xfer(m[0], m[1], 1'b0, (k == 2) ? 5'd3 : 5'(k), tb_b, sl_b);
        end
    xfer(1'b1, 1'b0, 1'b1, 5'd0, 8'h81, 8'h7E);
    xfer(1'b0, 1'b1, 1'b0, 5'd31, 8'h01, 8'h80);

    b_cpol = 0; b_cpha = 1;
    bwr(5'h00, 32'h81);
    s_tx = 8'h5A; sidx = 0; s_rx = '0; n_edge = 0; mon_on = 1;
    bwr(5'h0C, 32'h3C);
    repeat (40) @(posedge clk);
    brd(5'h04, rv);
    chk(rv == 32'h1, "R5 busy mid exchange", rv, 32'h1);
    bwr(5'h0C, 32'hFF);
    repeat (16 * 32 + 100) @(posedge clk);
    #1;
    chk(s_rx == 8'h3C, "R7 byte unchanged", s_rx, 8'h3C);
    chk(n_edge == 16, "R7 no second exchange", n_edge, 16);
    mon_on = 0;
    bwr(5'h04, 32'h4); brd(5'h04, rv);
    chk(rv == 32'h4, "R6 write one keeps full", rv, 32'h4);
    bwr(5'h04, 32'h0); brd(5'h04, rv);
    chk(rv == 32'h0, "R6 write zero clears", rv, 32'h0);
    brd(5'h10, rv);
    chk(rv == 32'h5A, "R4 byte kept after clear", rv, 32'h5A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule